// File: doc/BRIEF.md
# Rotating-Priority Memory Request Arbiter

This block picks the next client to serve when several agents share one external memory engine. On every cycle it looks for a pending request and issues at most one grant. A single strict-priority client, such as a display fetcher, is always looked at first. An attention line that stands for reconfiguration work comes second. After those two, a configurable group of round-robin clients is scanned from a rotating start position.

A client counts as pending when the top bit of its request word is set. The memory engine holds off all grants by raising its busy line. Each grant is a registered one-cycle pulse on the client's own grant line. The grant also appears as an encoded index. The start position moves on by one only when a round-robin client is granted. This simple rotation stays in on purpose, so the known fairness bias when one client is idle can be reproduced.

A saturating counter for each client records how many grants it has received, so that fairness can be measured. All grant lines are plain control signals and there is no handshake. A client that is granted is expected to withdraw its request, or to let the engine's busy line stop further grants.

Top module: `rot_prio_arbiter`

## Requirements
- R1: When the top bit of `pri_req_word` is set and `eng_busy` is low, the next cycle shows `gnt_pri` high and no other grant, whatever else is pending.
- R2: When `attn_req` is high, the priority client is not pending and `eng_busy` is low, the next cycle shows `gnt_attn` and no round-robin grant.
- R3: Round-robin client k is pending when bit REQ_W-1 of slice k of `rr_req_words` is set. The scan starts at a pointer that resets to 0 and covers N consecutive positions modulo N. The pointer advances by one, wrapping at N, only on a round-robin grant.
- R4: With N=5, clients 0 to 3 always pending and client 4 idle, 50 grants split 20/10/10/10/0 across clients 0 to 4.
- R5: Bits below the top bit of any request word have no effect on granting.
- R6: A grant is issued one cycle after the request is seen, lasts one cycle, and at most one grant line is high in any cycle. No grant follows a cycle in which `eng_busy` was high.
- R7: N is taken from `cfg_rr_clients` while `rst_n` is low. A value of 0 is used as 1, and values above RR_MAX are used as RR_MAX. Round-robin clients with index N or above are never granted.
- R8: `grant_counts` holds one CNT_W-bit counter per client. Slot 0 belongs to the priority client and slot k+1 to round-robin client k. All counters clear in reset, add one per grant, and hold at all ones.
- R9: `gnt_idx` is 0 for the priority client, 1 for attention and 2+k for round-robin client k, and it is valid while `gnt_valid` is high.
- R10: With nothing pending, no grant is issued. A request is granted in the first poll that sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rr_clients | input | $clog2(RR_MAX+1) | Round-robin client count, sampled in reset |
| pri_req_word | input | REQ_W | Priority client request word (top bit = pending) |
| attn_req | input | 1 | Attention/reconfiguration request |
| rr_req_words | input | RR_MAX*REQ_W | Round-robin request words, client k in slice k |
| eng_busy | input | 1 | Memory engine busy, suppresses grants |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_idx | output | $clog2(RR_MAX+2) | Encoded granted source |
| gnt_pri | output | 1 | Grant pulse, priority client |
| gnt_attn | output | 1 | Grant pulse, attention |
| gnt_rr | output | RR_MAX | Grant pulses, round-robin clients |
| grant_counts | output | (RR_MAX+1)*CNT_W | Saturating grant counters |

## Verification
Two functions can meet in one cycle. A priority or attention grant can arrive while round-robin requests are also pending, and only the round-robin grant may advance the pointer. The bench keeps every round-robin request asserted while it raises the priority and attention inputs. It then judges from the index of the next round-robin grant that the rotation did not move. The engine's busy line can also coincide with pending requests. That case is driven with all inputs pending, and the check is that no pulse appears and that the held request is granted in the first cycle after busy falls.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_ATTN = 2'd2,
    SRC_RR   = 2'd3
  } src_e;

  localparam int IDX_PRI     = 0;
  localparam int IDX_ATTN    = 1;
  localparam int IDX_RR_BASE = 2;
endpackage

// File: rtl/arb_rr_scan.sv
module arb_rr_scan #(
  parameter  int RR_MAX = 7,
  localparam int NW     = $clog2(RR_MAX + 1),
  localparam int PW     = 1 << NW
) (
  input  logic [RR_MAX-1:0] pend,
  input  logic [NW-1:0]     ptr,
  input  logic [NW-1:0]     n,
  output logic              hit,
  output logic [NW-1:0]     sel
);
  logic [PW-1:0] pend_pad;
  logic [NW:0]   pos;

  assign pend_pad = PW'(pend);

  // walk n positions starting at ptr, wrapping modulo n
  always_comb begin
    hit = 1'b0;
    sel = '0;
    pos = '0;
    for (int i = 0; i < RR_MAX; i++) begin
      pos = {1'b0, ptr} + (NW+1)'(i);
      if (pos >= {1'b0, n}) pos = pos - {1'b0, n};
      if (!hit && (i < int'(n)) && pend_pad[pos[NW-1:0]]) begin
        hit = 1'b1;
        sel = pos[NW-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_sat_cnt.sv
module arb_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
  end

  AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> (cnt == '1)); // R8
  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt)); // R8
endmodule

// File: rtl/rot_prio_arbiter.sv
module rot_prio_arbiter #(
  parameter  int RR_MAX  = 7,
  parameter  int REQ_W   = 32,
  parameter  int CNT_W   = 16,
  localparam int NW      = $clog2(RR_MAX + 1),
  localparam int CLIENTS = RR_MAX + 1,
  localparam int IDX_W   = $clog2(RR_MAX + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NW-1:0]            cfg_rr_clients,
  input  logic [REQ_W-1:0]         pri_req_word,
  input  logic                     attn_req,
  input  logic [RR_MAX*REQ_W-1:0]  rr_req_words,
  input  logic                     eng_busy,
  output logic                     gnt_valid,
  output logic [IDX_W-1:0]         gnt_idx,
  output logic                     gnt_pri,
  output logic                     gnt_attn,
  output logic [RR_MAX-1:0]        gnt_rr,
  output logic [CLIENTS*CNT_W-1:0] grant_counts
);
  import arb_pkg::*;

  logic [NW-1:0]     n_q, cfg_fix, ptr;
  logic [RR_MAX-1:0] rr_pend;
  logic              pri_pend, rr_hit;
  logic [NW-1:0]     rr_sel;
  src_e              src;
  logic [CLIENTS-1:0] cnt_inc;

  // configured client count, clamped into 1..RR_MAX
  always_comb begin
    if (cfg_rr_clients == '0)                 cfg_fix = NW'(1);
    else if (int'(cfg_rr_clients) > RR_MAX)   cfg_fix = NW'(RR_MAX);
    else                                      cfg_fix = cfg_rr_clients;
  end

  assign pri_pend = pri_req_word[REQ_W-1];

  for (genvar k = 0; k < RR_MAX; k++) begin : g_pend
    assign rr_pend[k] = rr_req_words[k*REQ_W + REQ_W-1] && (k < int'(n_q));
  end

  arb_rr_scan #(.RR_MAX(RR_MAX)) u_scan (
    .pend (rr_pend),
    .ptr  (ptr),
    .n    (n_q),
    .hit  (rr_hit),
    .sel  (rr_sel)
  );

  // fixed order: priority client, attention, rotating group
  always_comb begin
    if (eng_busy)      src = SRC_NONE;
    else if (pri_pend) src = SRC_PRI;
    else if (attn_req) src = SRC_ATTN;
    else if (rr_hit)   src = SRC_RR;
    else               src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q       <= cfg_fix;
      ptr       <= '0;
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      gnt_pri   <= 1'b0;
      gnt_attn  <= 1'b0;
      gnt_rr    <= '0;
    end else begin
      gnt_valid <= (src != SRC_NONE);
      gnt_pri   <= 1'b0;
      gnt_attn  <= 1'b0;
      gnt_rr    <= '0;
      gnt_idx   <= '0;
      case (src)
        SRC_PRI: begin
          gnt_pri <= 1'b1;
          gnt_idx <= IDX_W'(IDX_PRI);
        end
        SRC_ATTN: begin
          gnt_attn <= 1'b1;
          gnt_idx  <= IDX_W'(IDX_ATTN);
        end
        SRC_RR: begin
          gnt_rr[rr_sel] <= 1'b1;
          gnt_idx        <= IDX_W'(IDX_RR_BASE) + IDX_W'(rr_sel);
          ptr            <= (ptr == n_q - 1'b1) ? '0 : ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cnt_inc = {gnt_rr, gnt_pri};

  for (genvar c = 0; c < CLIENTS; c++) begin : g_cnt
    arb_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[c]),
      .cnt   (grant_counts[c*CNT_W +: CNT_W])
    );
  end

  AST_PRI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_req_word[REQ_W-1] && !eng_busy) |=> (gnt_pri && gnt_idx == '0)); // R1
  AST_ATTN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_req && !pri_req_word[REQ_W-1] && !eng_busy) |=> (gnt_attn && gnt_rr == '0)); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> !gnt_valid); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_pri, gnt_attn, gnt_rr}) == (gnt_valid ? 1 : 0)); // R6
  AST_OUT_OF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_rr >> n_q) == '0); // R7
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < n_q); // R3
  AST_PTR_ONLY_RR: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> (gnt_rr != '0)); // R3
endmodule

// File: tb/sim_rot_prio_arbiter.sv
module sim_rot_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int RR_MAX = 7;
  localparam int REQ_W = 32;
  localparam int CNT_W = 16;
  localparam int CLIENTS = RR_MAX + 1;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_rr_clients = 3'd5;
  logic [REQ_W-1:0] pri_req_word = '0;
  logic attn_req = 1'b0;
  logic [RR_MAX*REQ_W-1:0] rr_req_words = '0;
  logic eng_busy = 1'b0;
  logic gnt_valid;
  logic [3:0] gnt_idx;
  logic gnt_pri, gnt_attn;
  logic [RR_MAX-1:0] gnt_rr;
  logic [CLIENTS*CNT_W-1:0] grant_counts;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    int    idx;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_prio_arbiter #(.RR_MAX(RR_MAX), .REQ_W(REQ_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rr_clients(cfg_rr_clients),
    .pri_req_word(pri_req_word), .attn_req(attn_req),
    .rr_req_words(rr_req_words), .eng_busy(eng_busy),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_pri(gnt_pri),
    .gnt_attn(gnt_attn), .gnt_rr(gnt_rr), .grant_counts(grant_counts)
  );

  // monitor: compares the grant outputs with the oldest expected item
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [8:0] exp_vec;
      int act;
      e = sb_q.pop_front();
      vectors++;
      exp_vec = '0;
      if (e.idx == 0) exp_vec[8] = 1'b1;
      else if (e.idx == 1) exp_vec[7] = 1'b1;
      else if (e.idx >= 2) exp_vec[e.idx-2] = 1'b1;
      act = gnt_valid ? int'(gnt_idx) : -1;
      if (act != e.idx || {gnt_pri, gnt_attn, gnt_rr} != exp_vec) begin
        miscompares++;
        $display("FAIL %s: grant idx %0d lines %b, expected idx %0d lines %b",
                 e.tag, act, {gnt_pri, gnt_attn, gnt_rr}, e.idx, exp_vec);
      end
    end
  end

  // driver: inputs already set; expected grant appears after the next edge
  task automatic step(input int exp_idx, input string tag);
    @(posedge clk);
    sb_q.push_back('{idx: exp_idx, tag: tag});
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic set_rr(input logic [RR_MAX-1:0] m, input logic [REQ_W-1:0] word);
    for (int k = 0; k < RR_MAX; k++)
      rr_req_words[k*REQ_W +: REQ_W] = m[k] ? word : 32'h0000_1234;
  endtask

  task automatic do_reset(input logic [2:0] n);
    pri_req_word = '0; attn_req = 1'b0; eng_busy = 1'b0; set_rr('0, '0);
    cfg_rr_clients = n;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_rr_clients = 3'd6;
  endtask

  function automatic int cnt_of(input int slot);
    return int'(grant_counts[slot*CNT_W +: CNT_W]);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int pat[5];
    pat = '{0, 1, 2, 3, 0};

    do_reset(3'd5);
    chk(gnt_valid == 1'b0, "R6 reset no grant", int'(gnt_valid), 0);
    for (int s = 0; s < CLIENTS; s++)
      chk(cnt_of(s) == 0, "R8 counters clear", cnt_of(s), 0);

    step(-1, "R10 idle no grant");

    set_rr(7'h7F, 32'h8000_0000);
    for (int k = 0; k < 5; k++) step(2 + k, "R3 rotation N=5 / R9 idx");

    pri_req_word = 32'h8000_0000;
    step(0, "R1 priority over rr");
    pri_req_word = '0; attn_req = 1'b1;
    step(1, "R2 attention over rr");
    pri_req_word = 32'h8000_0000;
    step(0, "R1 priority over attention");
    pri_req_word = '0; attn_req = 1'b0;
    step(2, "R3 pointer held across pri/attn grants");

    eng_busy = 1'b1;
    step(-1, "R6 busy blocks grant");
    step(-1, "R6 busy blocks grant");
    eng_busy = 1'b0;
    step(3, "R10 grant first cycle after busy");

    set_rr(7'h7F, 32'h7FFF_FFFF);
    pri_req_word = 32'h7FFF_FFFF;
    step(-1, "R5 low bits ignored");
    pri_req_word = '0;

    set_rr(7'h60, 32'h8000_0000);
    step(-1, "R7 clients beyond N ignored");
    set_rr(7'h50, 32'h8000_0000);
    step(6, "R7 in-set client 4 wins over client 6");
    set_rr(7'h01, 32'h8000_0000);
    step(2, "R3 scan wraps from pointer 3 to client 0");

    do_reset(3'd5);
    set_rr(7'h0F, 32'h8000_0000);
    for (int i = 0; i < 50; i++) step(2 + pat[i % 5], "R4 idle-client sequence");
    set_rr('0, '0);
    step(-1, "R10 drain");
    step(-1, "R10 drain");
    chk(cnt_of(1) == 20, "R4 share client 0", cnt_of(1), 20);
    chk(cnt_of(2) == 10, "R4 share client 1", cnt_of(2), 10);
    chk(cnt_of(3) == 10, "R4 share client 2", cnt_of(3), 10);
    chk(cnt_of(4) == 10, "R4 share client 3", cnt_of(4), 10);
    chk(cnt_of(5) == 0,  "R4 share client 4", cnt_of(5), 0);

    do_reset(3'd0);
    set_rr(7'h7F, 32'h8000_0000);
    for (int i = 0; i < 3; i++) step(2, "R7 N=0 used as 1");
    set_rr(7'h02, 32'h8000_0000);
    step(-1, "R7 client 1 outside N=1");

    do_reset(3'd7);
    set_rr(7'h7F, 32'h8000_0000);
    for (int k = 0; k < 7; k++) step(2 + k, "R3 rotation N=7");
    step(2, "R3 wrap at N=7");

    do_reset(3'd5);
    pri_req_word = 32'h8000_0000;
    attn_req = 1'b1;
    repeat (65540) @(posedge clk);
    @(negedge clk);
    pri_req_word = '0; attn_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_of(0) == 65535, "R8 saturation at all ones", cnt_of(0), 65535);
    chk(cnt_of(1) == 0, "R1 rr never granted under priority", cnt_of(1), 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule